// File: doc/BRIEF.md
# Step Trigger Latch and Pulse Stretcher

This block turns the word that a step sequencer reads for its current step into a set of fixed-length trigger pulses, one line per channel. The pattern memory behind it is shared with a button-lamp scanner. The scanner keeps reading other addresses about a thousand times a second, so the read bus changes many times during one pulse. The outputs therefore cannot be a plain decode of the bus.

A step-advance pulse arms the block. The first cycle in which the armed block sees the current-step qualifier is the capture strobe: the bus word is loaded into the trigger registers and a timer starts. When the timer runs out, a clear strobe zeroes every trigger line. The pulse is 10 ms long, which is CLK_HZ/PULSE_RATE_HZ clock cycles with the default rate of 100. A new step advance that comes in during a pulse arms the block again. The next capture then loads the new word and restarts the timer.

Top module: `trig_stretch_top`

## Requirements
- R1: While rstN is low, every bit of trigOut is 0, and it stays 0 until the first capture after reset.
- R2: The block captures in a cycle where it is armed and rdValid is 1. In the next cycle trigOut equals the rdData value from the capture cycle (bit i drives channel i).
- R3: When the block is not armed and stepAdv is 0, rdValid and rdData have no effect on trigOut. Each capture uses up the arming.
- R4: After a capture, trigOut holds the captured word for exactly PULSE_CYCLES = CLK_HZ/PULSE_RATE_HZ cycles, then goes to all zeros, unless another capture comes first.
- R5: Between a capture and its clear, changes on rdData and rdValid do not change trigOut.
- R6: If stepAdv and rdValid are both 1 in the same cycle, the capture takes place in that cycle.
- R7: A step advance during an active pulse, followed by rdValid, loads the new word and restarts the full PULSE_CYCLES interval.
- R8: After stepAdv, the block stays armed over any number of cycles with rdValid at 0, and captures at the first cycle with rdValid at 1.
- R9: A channel whose captured bit is 0 stays low for the whole interval. No trigOut bit goes from 0 to 1 except in the cycle after a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepAdv | input | 1 | One-cycle pulse when the sequencer moves to a new step; arms a capture |
| rdValid | input | 1 | High while the read bus carries the current step's word |
| rdData | input | CH | Pattern memory read data, one bit per channel |
| trigOut | output | CH | Stretched trigger pulses, one per channel |

## Verification
Some rules are checked on every cycle by the assertions: the output stays stable whenever there is neither a capture nor a clear, a capture only happens with the qualifier high, the word loaded is the bus value, a clear always follows its capture after exactly the pulse length, and the lines are zero during reset and after a clear. Other behaviour depends on how stimulus is ordered, and only the bench scenarios show it. These are arming that persists over long gaps in the qualifier, the case where arming and the qualifier arrive together, restarting in the middle of a pulse, a reset that hits during a pulse, and scanner traffic that must be ignored while the block is not armed.

// File: rtl/trig_stretch_pkg.sv
package trig_stretch_pkg;
  // strobes the sequencing control hands to the trigger registers
  typedef struct packed {
    logic capture;  // load bus word into trigger registers
    logic clear;    // pulse interval elapsed, zero all triggers
  } ctrlStrobes_t;
endpackage

// File: rtl/trig_stretch_ctrl.sv
module trig_stretch_ctrl
  import trig_stretch_pkg::*;
#(
  parameter int PULSE_CYCLES = 500000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         stepAdv,
  input  logic         rdValid,
  output ctrlStrobes_t strb
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_CYCLES - 1);

  logic             armed;
  logic             active;
  logic [CNT_W-1:0] remain;

  // first qualified bus cycle after a step advance is the capture point
  always_comb begin
    strb.capture = (armed | stepAdv) & rdValid;
    strb.clear   = active & (remain == '0) & ~strb.capture;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      active <= 1'b0;
      remain <= '0;
    end else begin
      if (strb.capture)  armed <= 1'b0;
      else if (stepAdv)  armed <= 1'b1;

      if (strb.capture) begin
        active <= 1'b1;
        remain <= LOAD_VAL;
      end else if (strb.clear) begin
        active <= 1'b0;
      end else if (active) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_stretch_dp.sv
module trig_stretch_dp
  import trig_stretch_pkg::*;
#(
  parameter int CH = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strb,
  input  logic [CH-1:0] rdData,
  output logic [CH-1:0] trigOut
);
  for (genvar ch = 0; ch < CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              trigOut[ch] <= 1'b0;
      else if (strb.capture)  trigOut[ch] <= rdData[ch];
      else if (strb.clear)    trigOut[ch] <= 1'b0;
    end
  end
endmodule

// File: rtl/trig_stretch_top.sv
module trig_stretch_top
  import trig_stretch_pkg::*;
#(
  parameter int CH            = 7,
  parameter int CLK_HZ        = 50000000,
  parameter int PULSE_RATE_HZ = 100
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stepAdv,
  input  logic          rdValid,
  input  logic [CH-1:0] rdData,
  output logic [CH-1:0] trigOut
);
  localparam int PULSE_CYCLES = (CLK_HZ / PULSE_RATE_HZ > 0) ? CLK_HZ / PULSE_RATE_HZ : 1;

  ctrlStrobes_t strb;

  trig_stretch_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .stepAdv(stepAdv), .rdValid(rdValid), .strb(strb)
  );

  trig_stretch_dp #(.CH(CH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdData(rdData), .trigOut(trigOut)
  );
endmodule

// File: rtl/trig_stretch_chk.sv
module trig_stretch_chk #(
  parameter int CH           = 7,
  parameter int PULSE_CYCLES = 500000
) (
  input logic          clk,
  input logic          rstN,
  input logic          rdValid,
  input logic [CH-1:0] rdData,
  input logic [CH-1:0] trigOut,
  input logic          capStb,
  input logic          clrStb
);
  // cycles since the latest capture, kept here instead of a deep $past
  int unsigned sinceCap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       sinceCap <= 0;
    else if (capStb) sinceCap <= 0;
    else             sinceCap <= sinceCap + 1;
  end

  always @(posedge clk) begin
    if (!rstN) a_r1_reset_zero: assert (trigOut == '0);
  end

  a_r2_capture_word: assert property (@(posedge clk) disable iff (!rstN)
    capStb |=> trigOut == $past(rdData));

  a_r3_capture_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    capStb |-> rdValid);

  a_r4_clear_timing: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |-> sinceCap == PULSE_CYCLES - 1);

  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> trigOut == '0);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!capStb && !clrStb) |=> $stable(trigOut));

  a_r9_no_spurious_rise: assert property (@(posedge clk) disable iff (!rstN)
    !capStb |=> (trigOut & ~$past(trigOut)) == '0);
endmodule

bind trig_stretch_top trig_stretch_chk #(.CH(CH), .PULSE_CYCLES(PULSE_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdData(rdData), .trigOut(trigOut),
  .capStb(strb.capture), .clrStb(strb.clear)
);

// File: tb/trig_stretch_top_tb_top.sv
`timescale 1ns/1ps
module trig_stretch_top_tb_top;
  localparam int CH     = 7;
  localparam int CLK_HZ = 10000;
  localparam int RATE   = 100;
  localparam int PULSE  = CLK_HZ / RATE;  // 100 cycles in this bench

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stepAdv = 1'b0;
  logic          rdValid = 1'b0;
  logic [CH-1:0] rdData = '0;
  logic [CH-1:0] trigOut;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  // reference state from the requirements
  logic [CH-1:0] expTrig = '0;
  bit            expArmed = 1'b0;
  int            expLeft = 0;

  always #10 clk = ~clk;

  trig_stretch_top #(.CH(CH), .CLK_HZ(CLK_HZ), .PULSE_RATE_HZ(RATE)) dut_i (
    .clk(clk), .rstN(rstN), .stepAdv(stepAdv), .rdValid(rdValid),
    .rdData(rdData), .trigOut(trigOut)
  );

  function automatic void modelEdge(bit sa, bit v, logic [CH-1:0] d, bit rst);
    if (rst) begin
      expTrig = '0; expArmed = 0; expLeft = 0;
    end else if ((expArmed || sa) && v) begin
      expTrig = d; expLeft = PULSE; expArmed = 0;
    end else begin
      if (sa) expArmed = 1;
      if (expLeft > 0) begin
        expLeft--;
        if (expLeft == 0) expTrig = '0;
      end
    end
  endfunction

  task automatic check(string tag);
    nVec++;
    if (trigOut !== expTrig) begin
      nBad++;
      $display("FAIL %s: trigOut=%b expected=%b at %0t", tag, trigOut, expTrig, $time);
    end
  endtask

  // apply inputs after a falling edge, let one rising edge pass, compare
  task automatic cyc(bit sa, bit v, logic [CH-1:0] d, string tag);
    stepAdv = sa; rdValid = v; rdData = d;
    @(posedge clk);
    modelEdge(sa, v, d, !rstN);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, CH'($urandom), tag);
  endtask

  initial begin
    void'($urandom(32'h1A2B3C));
    @(negedge clk);
    cyc(0, 1, 7'h55, "R1");
    cyc(1, 1, 7'h7F, "R1");
    check("R1");
    rstN = 1'b1;
    // scanner traffic while not armed
    for (int i = 0; i < 20; i++) cyc(0, 1'($urandom), CH'($urandom), "R3");

    // R6: arm and qualifier together
    cyc(1, 1, 7'b1010011, "R6");
    // R5 / R9: bus noise during pulse, zero channels stay low
    for (int i = 0; i < PULSE - 2; i++) cyc(0, 1'($urandom), CH'($urandom), "R5_R9");
    cyc(0, 1, 7'h7F, "R4_last");
    cyc(0, 1, 7'h7F, "R4_clear");
    idle(5, "R4_after");

    // R8: arm, qualifier delayed
    cyc(1, 0, 7'h00, "R8");
    idle(37, "R8_wait");
    cyc(0, 1, 7'b0001111, "R8_capture");
    cyc(0, 1, 7'b1110000, "R3_consumed");
    idle(30, "R4");

    // R7: retrigger mid pulse with new word, full restart
    cyc(1, 0, 7'h2A, "R7");
    idle(3, "R7");
    cyc(0, 1, 7'b1100101, "R7_capture");
    idle(PULSE + 3, "R7_restart");

    // R1: reset in the middle of a pulse
    cyc(1, 1, 7'h3C, "R2");
    idle(10, "R2");
    rstN = 1'b0;
    cyc(0, 0, 7'h00, "R1_mid");
    cyc(1, 1, 7'h7F, "R1_mid");
    rstN = 1'b1;
    idle(3, "R1_after");

    // constrained random: rare step advances, busy scanner bus
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 60) == 0, ($urandom % 4) == 0, CH'($urandom), "R2_rand");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule